// File: doc/BRIEF.md
# Payload Cache Entry Replacement Manager

This block decides which on-adapter payload cache entry is handed out when a new transmit or receive needs a staging buffer. Every entry that has no transfer in flight sits on exactly one of three doubly linked lists:

- **free**: holds no useful data.
- **sent**: its payload has already gone out.
- **kept**: it holds received data that has not been forwarded yet.

An entry with a transfer in flight is on no list and is counted as pending.

Host-side control logic sends one event at a time. An event reports a completed send, a completed receive with or without cacheable data, an invalidation, demote advice, or a pend, which takes an entry off its list. The control logic asks for a replacement entry with a request/grant pair. The grant returns the entry ID and the list it was taken from, and the granted entry becomes pending.

The lists live in on-chip next/prev pointer arrays with one head pointer per list. Inside a list the newest entry sits at the head. A grant always takes that head, so replacement inside a list is most-recently-used. The lists are searched in a fixed order that protects received-but-unforwarded data.

The controller has three states:

- `ST_IDLE` accepts one operation.
- `ST_UNLINK` removes an entry from its list and raises the grant for an eviction.
- `ST_LINK` pushes an entry onto the head of its target list.

The controller moves between these states on four transitions:

- An event that needs removal goes IDLE→UNLINK.
- An unlink followed by a reinsert goes UNLINK→LINK.
- A completion goes IDLE→LINK.
- Every other path returns to IDLE.

Top module: `payload_repl_mgr`

## Requirements
- R1: After reset all entries are on the free list in ascending ID order, with ID 0 at the head. `ev_ready` is 1 and `evict_gnt` is 0, so successive grants return IDs 0, 1, 2 and so on with source 0.
- R2: Event code 1 (send complete) on a pending entry puts it at the head of the sent list.
- R3: Event code 2 (receive complete, data valid) on a pending entry puts it at the head of the kept list. Event code 3 (receive complete, short) on a pending entry puts it at the head of the free list.
- R4: Event codes 4 (invalidate) and 5 (demote) move an entry on the sent or kept list to the head of the free list. On an entry that is free or pending they have no effect.
- R5: A grant takes from the free list (`evict_src` 0) if it is non-empty. Otherwise it takes from the sent list (`evict_src` 1). Only when both are empty does it take from the kept list (`evict_src` 2).
- R6: Within a list the most recently added entry is granted first.
- R7: A pending entry is never granted, and a granted entry becomes pending. Event code 0 (pend) removes a listed entry from its list. Completion codes on an entry that is not pending have no effect, and neither do codes 6 and 7.
- R8: With all three lists empty, a held request gets no grant until an entry is released. It is then granted.
- R9: At most one operation is accepted per cycle, and `ev_ready` is low while an operation is in progress. An event and an eviction request presented in the same cycle are handled event first. A request accepted in IDLE raises `evict_gnt` for one cycle on the next cycle.
- R10: The three list counts plus the pending count always equal `N_ENTRIES`, so every entry released can be granted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_kind | input | 3 | Event code (0 pend, 1 send done, 2 receive ok, 3 receive short, 4 invalidate, 5 demote) |
| ev_id | input | ID_W | Entry the event refers to |
| ev_ready | output | 1 | Controller idle, so an event or request is accepted this cycle |
| evict_req | input | 1 | Request for a replacement entry, held until granted |
| evict_gnt | output | 1 | One-cycle grant |
| evict_id | output | ID_W | Granted entry |
| evict_src | output | 2 | List the entry came from (0 free, 1 sent, 2 kept) |

## Verification
The hardest situation to reach is a request with all three lists empty. Reaching it needs every entry to be pending, and entries become pending only by being granted or pended. The stimulus therefore drains the free list with a run of grants, then drains the sent and kept lists. It then holds the request for several cycles before one completion releases a single entry. A second hard case is a completion that lands in the same cycle as a request. The stimulus sets it up so that the kept list holds one entry and the completion feeds the free list. The grant's source then shows which operation was served first.

// File: rtl/prm_pkg.sv
package prm_pkg;
    // list location of an entry; value 3 doubles as the pending slot
    typedef enum logic [1:0] {
        L_UNB  = 2'd0,
        L_VIC  = 2'd1,
        L_PRI  = 2'd2,
        L_PEND = 2'd3
    } lst_t;

    typedef enum logic [2:0] {
        EV_PEND       = 3'd0,
        EV_SEND       = 3'd1,
        EV_RECV_OK    = 3'd2,
        EV_RECV_SHORT = 3'd3,
        EV_INVAL      = 3'd4,
        EV_DEMOTE     = 3'd5
    } evk_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNLINK = 2'd1,
        ST_LINK   = 2'd2
    } st_t;

    localparam int NLOC = 4;
endpackage

// File: rtl/prm_links.sv
module prm_links
    import prm_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int ID_W = $clog2(N_ENTRIES),
    localparam int PW   = ID_W + 1,
    localparam int CW   = $clog2(N_ENTRIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      do_unlink,
    input  logic                      do_link,
    input  logic [ID_W-1:0]           op_id,
    input  lst_t                      link_dst,
    output logic [NLOC-1:0][PW-1:0]   head_o,
    output logic [NLOC-1:0][CW-1:0]   cnt_o,
    output lst_t [N_ENTRIES-1:0]      loc_o
);
    localparam logic [PW-1:0] NIL = {1'b1, {ID_W{1'b0}}};

    logic [PW-1:0]             nxt_q [N_ENTRIES];
    logic [PW-1:0]             prv_q [N_ENTRIES];
    logic [NLOC-1:0][PW-1:0]   head_q;
    logic [NLOC-1:0][CW-1:0]   cnt_q;
    lst_t [N_ENTRIES-1:0]      loc_q;

    lst_t          cur_l;
    logic [PW-1:0] cur_p, cur_n, dst_h;

    always_comb begin
        cur_l = loc_q[op_id];
        cur_p = prv_q[op_id];
        cur_n = nxt_q[op_id];
        dst_h = head_q[link_dst];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                nxt_q[i] <= (i == N_ENTRIES - 1) ? NIL : PW'(i + 1);
                prv_q[i] <= (i == 0) ? NIL : PW'(i - 1);
                loc_q[i] <= L_UNB;
            end
            for (int k = 0; k < NLOC; k++) begin
                head_q[k] <= (k == 0) ? '0 : NIL;
                cnt_q[k]  <= (k == 0) ? CW'(N_ENTRIES) : '0;
            end
        end else if (do_unlink && cur_l != L_PEND) begin
            if (cur_p[PW-1]) head_q[cur_l] <= cur_n;
            else             nxt_q[cur_p[ID_W-1:0]] <= cur_n;
            if (!cur_n[PW-1]) prv_q[cur_n[ID_W-1:0]] <= cur_p;
            cnt_q[cur_l]  <= cnt_q[cur_l] - 1'b1;
            cnt_q[L_PEND] <= cnt_q[L_PEND] + 1'b1;
            loc_q[op_id]  <= L_PEND;
        end else if (do_link && cur_l == L_PEND && link_dst != L_PEND) begin
            nxt_q[op_id] <= dst_h;
            prv_q[op_id] <= NIL;
            if (!dst_h[PW-1]) prv_q[dst_h[ID_W-1:0]] <= {1'b0, op_id};
            head_q[link_dst] <= {1'b0, op_id};
            cnt_q[link_dst]  <= cnt_q[link_dst] + 1'b1;
            cnt_q[L_PEND]    <= cnt_q[L_PEND] - 1'b1;
            loc_q[op_id]     <= link_dst;
        end
    end

    assign head_o = head_q;
    assign cnt_o  = cnt_q;
    assign loc_o  = loc_q;
endmodule

// File: rtl/prm_pick.sv
module prm_pick
    import prm_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int ID_W = $clog2(N_ENTRIES),
    localparam int PW   = ID_W + 1
) (
    input  logic [NLOC-1:0][PW-1:0] head_i,
    output logic                    avail,
    output logic [ID_W-1:0]         pick_id,
    output lst_t                    pick_src
);
    // lower list index wins: free, then sent, then kept
    always_comb begin
        avail    = 1'b0;
        pick_id  = '0;
        pick_src = L_UNB;
        for (int k = NLOC - 2; k >= 0; k--) begin
            if (!head_i[k][PW-1]) begin
                avail    = 1'b1;
                pick_id  = head_i[k][ID_W-1:0];
                pick_src = lst_t'(2'(k));
            end
        end
    end
endmodule

// File: rtl/prm_ctrl.sv
module prm_ctrl
    import prm_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int ID_W = $clog2(N_ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    input  logic [2:0]      ev_kind,
    input  logic [ID_W-1:0] ev_id,
    input  lst_t            loc_ev,
    input  logic            evict_req,
    input  logic            pick_avail,
    input  logic [ID_W-1:0] pick_id,
    input  lst_t            pick_src,
    output logic            do_unlink,
    output logic            do_link,
    output logic [ID_W-1:0] op_id,
    output lst_t            op_dst,
    output logic            ev_ready,
    output logic            evict_gnt
);
    st_t             st_q, st_d;
    logic [ID_W-1:0] id_q, id_d;
    lst_t            dst_q, dst_d;
    logic            lnk_q, lnk_d;
    logic            evc_q, evc_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // latched operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            dst_q <= L_UNB;
            lnk_q <= 1'b0;
            evc_q <= 1'b0;
        end else begin
            id_q  <= id_d;
            dst_q <= dst_d;
            lnk_q <= lnk_d;
            evc_q <= evc_d;
        end
    end

    // next state and operation decode
    always_comb begin
        st_d  = st_q;
        id_d  = id_q;
        dst_d = dst_q;
        lnk_d = lnk_q;
        evc_d = evc_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ev_valid) begin
                    id_d  = ev_id;
                    evc_d = 1'b0;
                    case (evk_t'(ev_kind))
                        EV_PEND: if (loc_ev != L_PEND) begin
                            st_d  = ST_UNLINK;
                            lnk_d = 1'b0;
                        end
                        EV_SEND: if (loc_ev == L_PEND) begin
                            st_d  = ST_LINK;
                            dst_d = L_VIC;
                        end
                        EV_RECV_OK: if (loc_ev == L_PEND) begin
                            st_d  = ST_LINK;
                            dst_d = L_PRI;
                        end
                        EV_RECV_SHORT: if (loc_ev == L_PEND) begin
                            st_d  = ST_LINK;
                            dst_d = L_UNB;
                        end
                        EV_INVAL, EV_DEMOTE:
                            if (loc_ev == L_VIC || loc_ev == L_PRI) begin
                                st_d  = ST_UNLINK;
                                lnk_d = 1'b1;
                                dst_d = L_UNB;
                            end
                        default: ;
                    endcase
                end else if (evict_req && pick_avail) begin
                    id_d  = pick_id;
                    dst_d = pick_src;
                    lnk_d = 1'b0;
                    evc_d = 1'b1;
                    st_d  = ST_UNLINK;
                end
            end
            ST_UNLINK: st_d = lnk_q ? ST_LINK : ST_IDLE;
            ST_LINK:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ev_ready  = 1'b0;
        do_unlink = 1'b0;
        do_link   = 1'b0;
        evict_gnt = 1'b0;
        unique case (st_q)
            ST_IDLE:   ev_ready = 1'b1;
            ST_UNLINK: begin
                do_unlink = 1'b1;
                evict_gnt = evc_q;
            end
            ST_LINK:   do_link = 1'b1;
            default:   ;
        endcase
    end

    assign op_id  = id_q;
    assign op_dst = dst_q;
endmodule

// File: rtl/payload_repl_mgr.sv
module payload_repl_mgr
    import prm_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int ID_W = $clog2(N_ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    input  logic [2:0]      ev_kind,
    input  logic [ID_W-1:0] ev_id,
    output logic            ev_ready,
    input  logic            evict_req,
    output logic            evict_gnt,
    output logic [ID_W-1:0] evict_id,
    output logic [1:0]      evict_src
);
    localparam int PW = ID_W + 1;
    localparam int CW = $clog2(N_ENTRIES + 1);

    logic [NLOC-1:0][PW-1:0] head_w;
    logic [NLOC-1:0][CW-1:0] cnt_w;
    lst_t [N_ENTRIES-1:0]    loc_w;
    logic                    do_unlink, do_link, pick_avail;
    logic [ID_W-1:0]         op_id, pick_id;
    lst_t                    op_dst, pick_src, loc_ev;

    assign loc_ev = loc_w[ev_id];

    prm_ctrl #(.N_ENTRIES(N_ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_id(ev_id), .loc_ev(loc_ev), .evict_req(evict_req),
        .pick_avail(pick_avail), .pick_id(pick_id), .pick_src(pick_src),
        .do_unlink(do_unlink), .do_link(do_link), .op_id(op_id),
        .op_dst(op_dst), .ev_ready(ev_ready), .evict_gnt(evict_gnt)
    );

    prm_links #(.N_ENTRIES(N_ENTRIES)) u_links (
        .clk(clk), .rst_n(rst_n), .do_unlink(do_unlink), .do_link(do_link),
        .op_id(op_id), .link_dst(op_dst), .head_o(head_w), .cnt_o(cnt_w),
        .loc_o(loc_w)
    );

    prm_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .head_i(head_w), .avail(pick_avail), .pick_id(pick_id),
        .pick_src(pick_src)
    );

    assign evict_id  = op_id;
    assign evict_src = op_dst;
endmodule

// File: rtl/payload_repl_mgr_chk.sv
module payload_repl_mgr_chk #(
    parameter int N_ENTRIES = 8,
    localparam int ID_W = $clog2(N_ENTRIES),
    localparam int CW   = $clog2(N_ENTRIES + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ev_ready,
    input logic                  evict_req,
    input logic                  evict_gnt,
    input logic [ID_W-1:0]       evict_id,
    input logic [1:0]            evict_src,
    input logic [3:0][CW-1:0]    cnt_i,
    input logic [N_ENTRIES-1:0][1:0] loc_i
);
    assert_conserve_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt_i[0]) + 32'(cnt_i[1]) + 32'(cnt_i[2]) + 32'(cnt_i[3])) == N_ENTRIES);

    assert_order_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_gnt && evict_src == 2'd1) |-> cnt_i[0] == '0);

    assert_order_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_gnt && evict_src == 2'd2) |-> (cnt_i[0] == '0 && cnt_i[1] == '0));

    assert_src_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evict_gnt |-> (evict_src != 2'd3 && cnt_i[evict_src] != '0));

    assert_not_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evict_gnt |-> loc_i[evict_id] != 2'd3);

    assert_becomes_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evict_gnt |=> loc_i[$past(evict_id)] == 2'd3);

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evict_gnt |=> !evict_gnt);

    assert_gnt_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evict_gnt |-> (!ev_ready && $past(evict_req)));
endmodule

bind payload_repl_mgr payload_repl_mgr_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .evict_req(evict_req),
    .evict_gnt(evict_gnt), .evict_id(evict_id), .evict_src(evict_src),
    .cnt_i(cnt_w), .loc_i(loc_w)
);

// File: tb/payload_repl_mgr_bench.sv
module payload_repl_mgr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int ID_W = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_valid = 1'b0;
    logic [2:0]      ev_kind = '0;
    logic [ID_W-1:0] ev_id = '0;
    logic            ev_ready;
    logic            evict_req = 1'b0;
    logic            evict_gnt;
    logic [ID_W-1:0] evict_id;
    logic [1:0]      evict_src;

    int checks = 0;
    int fails  = 0;

    typedef struct { int id; int src; string tag; } exp_t;
    exp_t exp_q[$];

    // requirement model: front of each queue is the newest entry
    int  m_unb[$], m_vic[$], m_pri[$];
    bit  m_pend[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    payload_repl_mgr #(.N_ENTRIES(N)) u_payload_repl_mgr (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_id(ev_id), .ev_ready(ev_ready), .evict_req(evict_req),
        .evict_gnt(evict_gnt), .evict_id(evict_id), .evict_src(evict_src)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic void m_remove(input int id);
        foreach (m_unb[i]) if (m_unb[i] == id) begin m_unb.delete(i); return; end
        foreach (m_vic[i]) if (m_vic[i] == id) begin m_vic.delete(i); return; end
        foreach (m_pri[i]) if (m_pri[i] == id) begin m_pri.delete(i); return; end
    endfunction

    function automatic bit m_in(ref int q[$], input int id);
        foreach (q[i]) if (q[i] == id) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void m_event(input int kind, input int id);
        case (kind)
            0: if (!m_pend[id]) begin m_remove(id); m_pend[id] = 1; end
            1: if (m_pend[id]) begin m_vic.push_front(id); m_pend[id] = 0; end
            2: if (m_pend[id]) begin m_pri.push_front(id); m_pend[id] = 0; end
            3: if (m_pend[id]) begin m_unb.push_front(id); m_pend[id] = 0; end
            4, 5: if (m_in(m_vic, id) || m_in(m_pri, id)) begin
                m_remove(id); m_unb.push_front(id);
            end
            default: ;
        endcase
    endfunction

    function automatic void expect_pick(input string tag);
        exp_t e;
        e.tag = tag;
        if (m_unb.size() > 0)      begin e.id = m_unb.pop_front(); e.src = 0; end
        else if (m_vic.size() > 0) begin e.id = m_vic.pop_front(); e.src = 1; end
        else                       begin e.id = m_pri.pop_front(); e.src = 2; end
        m_pend[e.id] = 1;
        exp_q.push_back(e);
    endfunction

    task automatic send_ev(input int kind, input int id);
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
        m_event(kind, id);
        ev_valid = 1'b1;
        ev_kind  = 3'(kind);
        ev_id    = ID_W'(id);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_gnt_release();
        @(negedge clk);
        while (!evict_gnt) @(negedge clk);
        evict_req = 1'b0;
    endtask

    task automatic do_evict(input string tag);
        expect_pick(tag);
        @(negedge clk);
        evict_req = 1'b1;
        wait_gnt_release();
    endtask

    // monitor: compare every grant against the scoreboard
    always @(negedge clk) begin
        if (rst_n && evict_gnt) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected grant", int'(evict_id), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(evict_id) == e.id, {e.tag, " id"}, int'(evict_id), e.id);
                check(int'(evict_src) == e.src, {e.tag, " src"}, int'(evict_src), e.src);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_unb.push_back(i); m_pend[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ev_ready == 1'b1, "R1 reset ev_ready", int'(ev_ready), 1);
        check(evict_gnt == 1'b0, "R1 reset evict_gnt", int'(evict_gnt), 0);

        // R1: ascending IDs from free list
        for (int i = 0; i < 3; i++) do_evict("R1 reset order");

        // R2 / R3 completions
        send_ev(1, 0);
        send_ev(2, 1);
        send_ev(2, 2);
        // R7 / R4 ignored events
        send_ev(1, 0);      // send done on listed entry
        send_ev(4, 5);      // invalidate on free entry
        send_ev(7, 3);      // unused code
        send_ev(0, 6);      // R7 pend removes 6 from free list
        for (int i = 0; i < 4; i++) do_evict("R7 pend skipped");
        do_evict("R5 sent after free");
        do_evict("R6 kept newest");
        do_evict("R6 kept older");

        // all pending now
        send_ev(1, 3);
        send_ev(1, 4);
        send_ev(2, 5);
        send_ev(3, 6);      // R3 short receive to free
        send_ev(4, 7);      // R4 invalidate on pending: ignored
        send_ev(5, 5);      // R4 demote kept entry
        send_ev(4, 4);      // R4 invalidate sent entry
        for (int i = 0; i < 3; i++) do_evict("R4 free newest first");
        do_evict("R2 sent list");

        // R8: blocked request with every list empty
        @(negedge clk);
        evict_req = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (evict_gnt) seen++;
            end
            check(seen == 0, "R8 no grant while empty", seen, 0);
        end
        send_ev(2, 2);
        expect_pick("R8 released entry");
        wait_gnt_release();

        // R9: event and request in the same cycle
        send_ev(2, 0);
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
        m_event(3, 1);
        expect_pick("R9 event first");
        ev_valid = 1'b1; ev_kind = 3'd3; ev_id = ID_W'(1);
        evict_req = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check(ev_ready == 1'b0, "R9 busy after accept", int'(ev_ready), 0);
        wait_gnt_release();
        do_evict("R9 then kept");

        // R10: release every entry, each granted exactly once
        for (int i = 0; i < N; i++) send_ev(1, i);
        for (int i = 0; i < N; i++) do_evict("R10 conservation");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all grants seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule